// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard

This block holds one ready bit for each entry of a unified physical register file in an out-of-order core. Every register class shares a single flat index space, so the same bit vector serves integer, floating-point, vector and miscellaneous registers alike. Issue logic asks for readiness through several query ports. Writeback marks results ready through the set ports. Rename marks newly allocated destinations not ready through the clear ports.

Each port carries a full register descriptor: flat index, class, class-local index and a fixed-mapping flag. A register with a fixed mapping never depends on storage. Queries for it answer ready, and updates aimed at it are dropped. The hardwired integer zero register can never be made not ready. Any valid port that presents a flat index at or beyond the register count raises a combinational error flag, and that request changes nothing.

Top module: `regready_scoreboard`

## Requirements
- R1: During reset and after it is released, every stored ready bit is 1, so all in-range queries return ready until a clear occurs.
- R2: A valid clear with fixed flag 0, an in-range index and no zero-register match makes that register read not ready from the next cycle on.
- R3: A valid set with fixed flag 0 and an in-range index makes that register ready from the next cycle. A query in the same cycle as the update still returns the old value.
- R4: A query with the fixed flag at 1 returns ready whatever the stored bit is.
- R5: A set or clear with the fixed flag at 1 leaves every stored bit unchanged.
- R6: A clear with class 2'b00 (integer) and class-local index equal to ZERO_IDX is ignored. A clear with the same local index in class 2'b01 (floating point) takes effect.
- R7: When a set and a clear hit the same register in one cycle, the register becomes not ready.
- R8: `range_err` is 1 in any cycle where a valid query, set or clear port has a flat index of NUM_REGS or more. Such an update changes no stored bit.
- R9: A non-fixed query with an out-of-range flat index returns not ready.
- R10: All ports act independently in the same cycle. Several clears to different registers all take effect, and each query port reports its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | RD_PORTS | Query port valid; used only for the range check |
| rd_flat | input | RD_PORTS x IDX_W | Query flat index |
| rd_cls | input | RD_PORTS x 2 | Query register class (00 int, 01 fp, 10 vec, 11 misc) |
| rd_lidx | input | RD_PORTS x LIDX_W | Query class-local index |
| rd_fixed | input | RD_PORTS | Query fixed-mapping flag |
| rd_ready | output | RD_PORTS | Readiness answer per query port |
| set_vld | input | SET_PORTS | Set-ready request valid |
| set_flat | input | SET_PORTS x IDX_W | Set-ready flat index |
| set_fixed | input | SET_PORTS | Set-ready fixed-mapping flag |
| clr_vld | input | CLR_PORTS | Clear-ready request valid |
| clr_flat | input | CLR_PORTS x IDX_W | Clear-ready flat index |
| clr_cls | input | CLR_PORTS x 2 | Clear-ready register class |
| clr_lidx | input | CLR_PORTS x LIDX_W | Clear-ready class-local index |
| clr_fixed | input | CLR_PORTS | Clear-ready fixed-mapping flag |
| range_err | output | 1 | Some valid port presented an out-of-range flat index |

## Verification
A wrong stored bit shows up the next time a non-fixed query reaches that flat index. One cycle after the faulty update, the query returns the wrong readiness. A dropped zero-register guard shows up the cycle after the clear, as a not-ready answer for the integer zero register. A bad range decode shows up in the same cycle as the request, on `range_err`. When that bad decode lets a write through, neighbouring registers read wrongly from the following cycle.

// File: rtl/psb_pkg.sv
package psb_pkg;
    typedef enum logic [1:0] {
        CLS_INT = 2'b00,
        CLS_FP  = 2'b01,
        CLS_VEC = 2'b10,
        CLS_MSC = 2'b11
    } reg_cls_e;
endpackage

// File: rtl/psb_decode.sv
// Turns one update request into a one-hot write mask over the ready vector.
module psb_decode #(
    parameter int NUM_REGS   = 48,
    parameter int IDX_W      = 6,
    parameter int LIDX_W     = 6,
    parameter int ZERO_IDX   = 0,
    parameter bit GUARD_ZERO = 1'b0
) (
    input  logic              vld,
    input  logic [IDX_W-1:0]  flat,
    input  logic [1:0]        cls,
    input  logic [LIDX_W-1:0] lidx,
    input  logic              fixed,
    output logic              bad_idx,
    output logic [NUM_REGS-1:0] mask
);
    import psb_pkg::*;

    logic in_range;
    logic zero_hit;

    always_comb begin
        in_range = (int'(flat) < NUM_REGS);
        bad_idx  = vld && !in_range;
        zero_hit = GUARD_ZERO && (cls == CLS_INT) && (lidx == LIDX_W'(ZERO_IDX));
        mask     = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (vld && !fixed && in_range && !zero_hit && (int'(flat) == i))
                mask[i] = 1'b1;
        end
    end
endmodule

// File: rtl/psb_query.sv
// One readiness query port: fixed-mapping bypass plus range-checked lookup.
module psb_query #(
    parameter int NUM_REGS = 48,
    parameter int IDX_W    = 6
) (
    input  logic [NUM_REGS-1:0] ready_vec,
    input  logic                vld,
    input  logic [IDX_W-1:0]    flat,
    input  logic                fixed,
    output logic                ready,
    output logic                bad_idx
);
    logic in_range;

    always_comb begin
        in_range = (int'(flat) < NUM_REGS);
        bad_idx  = vld && !in_range;
        ready    = 1'b0;
        if (fixed)
            ready = 1'b1;
        else if (in_range)
            ready = ready_vec[flat];
    end
endmodule

// File: rtl/regready_scoreboard.sv
module regready_scoreboard #(
    parameter int NUM_REGS  = 48,
    parameter int ZERO_IDX  = 0,
    parameter int RD_PORTS  = 2,
    parameter int SET_PORTS = 2,
    parameter int CLR_PORTS = 2,
    parameter int LIDX_W    = 6,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [RD_PORTS-1:0]               rd_vld,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_flat,
    input  logic [RD_PORTS-1:0][1:0]          rd_cls,
    input  logic [RD_PORTS-1:0][LIDX_W-1:0]   rd_lidx,
    input  logic [RD_PORTS-1:0]               rd_fixed,
    output logic [RD_PORTS-1:0]               rd_ready,
    input  logic [SET_PORTS-1:0]              set_vld,
    input  logic [SET_PORTS-1:0][IDX_W-1:0]   set_flat,
    input  logic [SET_PORTS-1:0]              set_fixed,
    input  logic [CLR_PORTS-1:0]              clr_vld,
    input  logic [CLR_PORTS-1:0][IDX_W-1:0]   clr_flat,
    input  logic [CLR_PORTS-1:0][1:0]         clr_cls,
    input  logic [CLR_PORTS-1:0][LIDX_W-1:0]  clr_lidx,
    input  logic [CLR_PORTS-1:0]              clr_fixed,
    output logic                              range_err
);
    typedef struct packed {
        logic [NUM_REGS-1:0] ready;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [SET_PORTS-1:0][NUM_REGS-1:0] set_mask;
    logic [CLR_PORTS-1:0][NUM_REGS-1:0] clr_mask;
    logic [SET_PORTS-1:0] set_bad;
    logic [CLR_PORTS-1:0] clr_bad;
    logic [RD_PORTS-1:0]  rd_bad;
    logic [NUM_REGS-1:0]  set_any, clr_any, ready_q;

    // The class and local index do not matter for set requests.
    for (genvar s = 0; s < SET_PORTS; s++) begin : g_set
        psb_decode #(
            .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .LIDX_W(LIDX_W),
            .ZERO_IDX(ZERO_IDX), .GUARD_ZERO(1'b0)
        ) i_dec (
            .vld(set_vld[s]), .flat(set_flat[s]), .cls(2'b00),
            .lidx('0), .fixed(set_fixed[s]),
            .bad_idx(set_bad[s]), .mask(set_mask[s])
        );
    end

    for (genvar c = 0; c < CLR_PORTS; c++) begin : g_clr
        psb_decode #(
            .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .LIDX_W(LIDX_W),
            .ZERO_IDX(ZERO_IDX), .GUARD_ZERO(1'b1)
        ) i_dec (
            .vld(clr_vld[c]), .flat(clr_flat[c]), .cls(clr_cls[c]),
            .lidx(clr_lidx[c]), .fixed(clr_fixed[c]),
            .bad_idx(clr_bad[c]), .mask(clr_mask[c])
        );
    end

    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
        psb_query #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_qry (
            .ready_vec(st_q.ready), .vld(rd_vld[r]), .flat(rd_flat[r]),
            .fixed(rd_fixed[r]), .ready(rd_ready[r]), .bad_idx(rd_bad[r])
        );
    end

    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int s = 0; s < SET_PORTS; s++) set_any |= set_mask[s];
        for (int c = 0; c < CLR_PORTS; c++) clr_any |= clr_mask[c];
        st_d       = st_q;
        // A clear from allocation wins over a set in the same cycle.
        st_d.ready = (st_q.ready | set_any) & ~clr_any;
        range_err  = (|set_bad) | (|clr_bad) | (|rd_bad);
        ready_q    = st_q.ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ready <= '1;
        else        st_q       <= st_d;
    end

    // rd_cls and rd_lidx feed only the checker's zero-register property.
    logic unused_rd_desc;
    assign unused_rd_desc = ^{rd_cls, rd_lidx};
endmodule

module psb_checker #(
    parameter int NUM_REGS  = 48,
    parameter int ZERO_IDX  = 0,
    parameter int RD_PORTS  = 2,
    parameter int SET_PORTS = 2,
    parameter int CLR_PORTS = 2,
    parameter int LIDX_W    = 6,
    parameter int IDX_W     = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_REGS-1:0]              ready_q,
    input logic [RD_PORTS-1:0]              rd_vld,
    input logic [RD_PORTS-1:0][IDX_W-1:0]   rd_flat,
    input logic [RD_PORTS-1:0][1:0]         rd_cls,
    input logic [RD_PORTS-1:0][LIDX_W-1:0]  rd_lidx,
    input logic [RD_PORTS-1:0]              rd_fixed,
    input logic [RD_PORTS-1:0]              rd_ready,
    input logic [SET_PORTS-1:0]             set_vld,
    input logic [SET_PORTS-1:0][IDX_W-1:0]  set_flat,
    input logic [SET_PORTS-1:0]             set_fixed,
    input logic [CLR_PORTS-1:0]             clr_vld,
    input logic [CLR_PORTS-1:0][IDX_W-1:0]  clr_flat,
    input logic [CLR_PORTS-1:0][1:0]        clr_cls,
    input logic [CLR_PORTS-1:0][LIDX_W-1:0] clr_lidx,
    input logic [CLR_PORTS-1:0]             clr_fixed
);
    // R1
    reset_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&ready_q));

    // R5
    no_fall_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&(~clr_vld | clr_fixed)) |=> ((ready_q & $past(ready_q)) == $past(ready_q)));

    for (genvar c = 0; c < CLR_PORTS; c++) begin : g_clr_chk
        // R2
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vld[c] && !clr_fixed[c] && int'(clr_flat[c]) < NUM_REGS &&
             !(clr_cls[c] == 2'b00 && clr_lidx[c] == LIDX_W'(ZERO_IDX)))
            |=> !ready_q[$past(clr_flat[c])]);
    end

    for (genvar s = 0; s < SET_PORTS; s++) begin : g_set_chk
        // R3
        set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vld[s] && !set_fixed[s] && int'(set_flat[s]) < NUM_REGS && clr_vld == '0)
            |=> ready_q[$past(set_flat[s])]);
    end

    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd_chk
        // R6
        zero_reg_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_vld[r] && !rd_fixed[r] && rd_cls[r] == 2'b00 &&
             rd_lidx[r] == LIDX_W'(ZERO_IDX) && int'(rd_flat[r]) < NUM_REGS)
            |-> rd_ready[r]);
        // R4
        fixed_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_fixed[r] |-> rd_ready[r]);
    end
endmodule

bind regready_scoreboard psb_checker #(
    .NUM_REGS(NUM_REGS), .ZERO_IDX(ZERO_IDX), .RD_PORTS(RD_PORTS),
    .SET_PORTS(SET_PORTS), .CLR_PORTS(CLR_PORTS), .LIDX_W(LIDX_W), .IDX_W(IDX_W)
) i_psb_checker (
    .clk(clk), .rst_n(rst_n), .ready_q(ready_q),
    .rd_vld(rd_vld), .rd_flat(rd_flat), .rd_cls(rd_cls), .rd_lidx(rd_lidx),
    .rd_fixed(rd_fixed), .rd_ready(rd_ready),
    .set_vld(set_vld), .set_flat(set_flat), .set_fixed(set_fixed),
    .clr_vld(clr_vld), .clr_flat(clr_flat), .clr_cls(clr_cls),
    .clr_lidx(clr_lidx), .clr_fixed(clr_fixed)
);

// File: tb/test_regready_scoreboard.sv
`timescale 1ns/100ps
module test_regready_scoreboard;
    localparam int NUM_REGS = 48;
    localparam int IDX_W    = 6;
    localparam int LIDX_W   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]              rd_vld;
    logic [1:0][IDX_W-1:0]   rd_flat;
    logic [1:0][1:0]         rd_cls;
    logic [1:0][LIDX_W-1:0]  rd_lidx;
    logic [1:0]              rd_fixed;
    logic [1:0]              rd_ready;
    logic [1:0]              set_vld;
    logic [1:0][IDX_W-1:0]   set_flat;
    logic [1:0]              set_fixed;
    logic [1:0]              clr_vld;
    logic [1:0][IDX_W-1:0]   clr_flat;
    logic [1:0][1:0]         clr_cls;
    logic [1:0][LIDX_W-1:0]  clr_lidx;
    logic [1:0]              clr_fixed;
    logic                    range_err;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    regready_scoreboard i_regready_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .rd_vld(rd_vld), .rd_flat(rd_flat), .rd_cls(rd_cls), .rd_lidx(rd_lidx),
        .rd_fixed(rd_fixed), .rd_ready(rd_ready),
        .set_vld(set_vld), .set_flat(set_flat), .set_fixed(set_fixed),
        .clr_vld(clr_vld), .clr_flat(clr_flat), .clr_cls(clr_cls),
        .clr_lidx(clr_lidx), .clr_fixed(clr_fixed), .range_err(range_err)
    );

    // {op(0 none,1 clear,2 set), flat, class, local index, fixed, expected ready}
    localparam logic [17:0] TBL [0:9] = '{
        {2'd1, 6'd5,  2'd0, 6'd5, 1'b0, 1'b0},  // R2
        {2'd2, 6'd5,  2'd0, 6'd5, 1'b0, 1'b1},  // R3
        {2'd1, 6'd0,  2'd0, 6'd0, 1'b0, 1'b1},  // R6 int zero guarded
        {2'd1, 6'd6,  2'd1, 6'd0, 1'b0, 1'b0},  // R6 fp local 0 clears
        {2'd1, 6'd7,  2'd0, 6'd7, 1'b1, 1'b1},  // R4 fixed query
        {2'd0, 6'd7,  2'd0, 6'd7, 1'b0, 1'b1},  // R5 fixed clear dropped
        {2'd1, 6'd8,  2'd2, 6'd8, 1'b0, 1'b0},  // R2
        {2'd2, 6'd8,  2'd2, 6'd8, 1'b1, 1'b1},  // R4 fixed query
        {2'd0, 6'd8,  2'd2, 6'd8, 1'b0, 1'b0},  // R5 fixed set dropped
        {2'd0, 6'd50, 2'd0, 6'd9, 1'b0, 1'b0}   // R9 out-of-range query
    };

    task automatic idle();
        rd_vld = '0; rd_flat = '0; rd_cls = '0; rd_lidx = '0; rd_fixed = '0;
        set_vld = '0; set_flat = '0; set_fixed = '0;
        clr_vld = '0; clr_flat = '0; clr_cls = '0; clr_lidx = '0; clr_fixed = '0;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic query(input int p, input logic [5:0] f, input logic [1:0] c,
                         input logic [5:0] l, input logic fx);
        rd_vld[p] = 1'b1; rd_flat[p] = f; rd_cls[p] = c; rd_lidx[p] = l; rd_fixed[p] = fx;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset leaves everything ready
        @(negedge clk);
        for (int i = 0; i < NUM_REGS; i += 9) begin
            query(0, 6'(i), 2'd1, 6'(i), 1'b0);
            #1 check("R1", rd_ready[0], 1'b1);
        end
        idle();

        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            idle();
            if (TBL[k][17:16] == 2'd1) begin
                clr_vld[0] = 1'b1; clr_flat[0] = TBL[k][15:10]; clr_cls[0] = TBL[k][9:8];
                clr_lidx[0] = TBL[k][7:2]; clr_fixed[0] = TBL[k][1];
            end else if (TBL[k][17:16] == 2'd2) begin
                set_vld[0] = 1'b1; set_flat[0] = TBL[k][15:10]; set_fixed[0] = TBL[k][1];
            end
            @(negedge clk);
            idle();
            query(0, TBL[k][15:10], TBL[k][9:8], TBL[k][7:2], TBL[k][1]);
            #1 check("R2/R3/R4/R5/R6/R9 table", rd_ready[0], TBL[k][0]);
        end

        // R3: same-cycle query sees old value, next cycle sees new
        @(negedge clk); idle();
        set_vld[0] = 1'b1; set_flat[0] = 6'd8;
        query(0, 6'd8, 2'd2, 6'd8, 1'b0);
        #1 check("R3 same cycle", rd_ready[0], 1'b0);
        @(negedge clk); set_vld = '0;
        #1 check("R3 next cycle", rd_ready[0], 1'b1);

        // R7: set and clear on the same register
        @(negedge clk); idle();
        set_vld[1] = 1'b1; set_flat[1] = 6'd20;
        clr_vld[1] = 1'b1; clr_flat[1] = 6'd20; clr_cls[1] = 2'd1; clr_lidx[1] = 6'd3;
        @(negedge clk); idle();
        query(1, 6'd20, 2'd1, 6'd3, 1'b0);
        #1 check("R7", rd_ready[1], 1'b0);

        // R8: out-of-range clear flags error and changes nothing
        @(negedge clk); idle();
        clr_vld[0] = 1'b1; clr_flat[0] = 6'd50; clr_cls[0] = 2'd1; clr_lidx[0] = 6'd2;
        #1 check("R8 err flag", range_err, 1'b1);
        @(negedge clk); idle();
        #1 check("R8 err clear", range_err, 1'b0);
        query(0, 6'd2, 2'd1, 6'd2, 1'b0);
        query(1, 6'd34, 2'd1, 6'd2, 1'b0);
        #1 check("R8 reg2 intact", rd_ready[0], 1'b1);
        check("R8 reg34 intact", rd_ready[1], 1'b1);
        idle(); rd_vld[1] = 1'b1; rd_flat[1] = 6'd63;
        #1 check("R8 query range", range_err, 1'b1);

        // R10: two clears, two queries at once
        @(negedge clk); idle();
        clr_vld = 2'b11; clr_flat[0] = 6'd30; clr_flat[1] = 6'd31;
        clr_cls[0] = 2'd2; clr_cls[1] = 2'd3; clr_lidx[0] = 6'd1; clr_lidx[1] = 6'd1;
        @(negedge clk); idle();
        query(0, 6'd30, 2'd2, 6'd1, 1'b0);
        query(1, 6'd31, 2'd3, 6'd1, 1'b0);
        #1 check("R10 port0", rd_ready[0], 1'b0);
        check("R10 port1", rd_ready[1], 1'b0);
        query(1, 6'd32, 2'd3, 6'd2, 1'b0);
        #1 check("R10 neighbour", rd_ready[1], 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule